// File: doc/BRIEF.md
# Quadrature Encoder Front End with Noise Filter and Qualified Index Reset

This block takes the three raw lines of an incremental encoder: the two phase signals and the once-per-revolution index. It turns them into a 16-bit position count. Each line can pass through a digital noise filter. The filter samples on a clock enable from a programmable prescaler, and a new level is accepted only after it has been seen on three consecutive sample enables. A control bit bypasses the filter, so the raw pins drive the counter directly.

The counter runs in one of two modes. In the 4x mode it steps on every edge of either phase. In the 2x mode it steps only on edges of phase A. The phase relation sets the direction. A rising edge on the index line clears the counter, but only when the phase levels match a programmed pattern. What the pattern means depends on the count mode.

If both phases change on the same sample, the step is illegal. The block records this in a sticky error flag and raises an interrupt output, unless a control bit masks it.

Top module: `enc_front`

## Requirements
- R1: The control word reads back with bits 15..11 and 3..0 as zero. Bits 10..4 hold the last written value. All bits are zero after reset. Bit fields: [10:9] index pattern, [8] error interrupt mask, [7] filter enable, [6:4] prescale code.
- R2: Prescale codes 0 to 7 give sample enables every 1, 2, 4, 16, 32, 64, 128 and 256 clocks. There is no divide by 8. With the filter enabled, a phase change held steady reaches the count 2R+2 to 3R+1 clocks after it is applied, where R is the selected ratio.
- R3: A filtered line takes a new level only after three consecutive sample enables see that level. A pulse shorter than two sample periods never reaches the counter.
- R4: With control bit 7 clear, the raw lines drive the counter, and a phase edge shows in the count one clock later.
- R5: In 4x mode (mode_4x=1) every single-phase edge changes the count by one. The (A,B) sequence 00, 10, 11, 01 counts up, and the reverse sequence counts down.
- R6: In 2x mode (mode_4x=0) only edges of phase A change the count. The direction rule is the same as in 4x mode, and edges of phase B leave the count unchanged.
- R7: In 4x mode a rising index edge clears the count only when B equals bit 10 and A equals bit 9.
- R8: In 2x mode a rising index edge clears the count only when the phase chosen by bit 10 (0 = A, 1 = B) equals bit 9.
- R9: When both phases change on the same sample, err_flag is set and the count does not step. The flag stays set until err_clr is pulsed.
- R10: err_irq equals err_flag while control bit 8 is 0, and is 0 while bit 8 is 1.
- R11: The count wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a_in | input | 1 | Raw phase A |
| phase_b_in | input | 1 | Raw phase B |
| index_in | input | 1 | Raw index line |
| mode_4x | input | 1 | 1 = 4x counting, 0 = 2x counting |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word read data |
| err_clr | input | 1 | Pulse to clear the sticky error flag |
| pos_count | output | 16 | Position count |
| err_flag | output | 1 | Sticky illegal-transition flag |
| err_irq | output | 1 | Maskable error interrupt |

## Verification
Random walks of legal quadrature steps in both directions check that the counter tracks direction in each mode. In 2x mode the walks confirm that B-only edges leave the count alone. Injected double-phase toggles separate a legal step from an error: the flag sets and the count holds. Random index pulses under random patterns, in both modes, show that the clear happens only when the mode-specific match holds. Directed runs measure the filtered latency for every prescale code, which reveals a wrong divide table or a wrong sample count, and pulses shorter than two sample periods show that glitches are rejected.

// File: rtl/enc_pkg.sv
package enc_pkg;

    localparam int CTL_W     = 16;
    localparam int MAX_SHIFT = 8;

    typedef enum logic {
        MODE_2X = 1'b0,
        MODE_4X = 1'b1
    } cnt_mode_e;

    typedef struct packed {
        logic [1:0] pattern;
        logic       err_mask;
        logic       filt_en;
        logic [2:0] div_code;
    } ctl_t;

    function automatic logic [3:0] div_shift(input logic [2:0] code);
        logic [3:0] s;
        case (code)
            3'd0: s = 4'd0;
            3'd1: s = 4'd1;
            3'd2: s = 4'd2;
            3'd3: s = 4'd4;
            3'd4: s = 4'd5;
            3'd5: s = 4'd6;
            3'd6: s = 4'd7;
            default: s = 4'd8;
        endcase
        return s;
    endfunction

    function automatic ctl_t word_to_ctl(input logic [6:0] bits10_4);
        ctl_t c;
        c.pattern  = bits10_4[6:5];
        c.err_mask = bits10_4[4];
        c.filt_en  = bits10_4[3];
        c.div_code = bits10_4[2:0];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_to_word(input ctl_t c);
        return {5'b0, c.pattern, c.err_mask, c.filt_en, c.div_code, 4'b0};
    endfunction

    function automatic logic index_match(input cnt_mode_e m, input logic [1:0] pat,
                                         input logic a, input logic b);
        logic hit;
        if (m == MODE_4X) hit = (b == pat[1]) && (a == pat[0]);
        else              hit = ((pat[1] ? b : a) == pat[0]);
        return hit;
    endfunction

endpackage

// File: rtl/enc_prescaler.sv
module enc_prescaler
    import enc_pkg::*;
#(
    parameter int DIVW = MAX_SHIFT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] div_code,
    output logic       tick
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] lim;
    logic [DIVW:0]   ratio;
    logic [DIVW:0]   ratio_m1;

    always_comb begin
        ratio    = (DIVW+1)'(1) << div_shift(div_code);
        ratio_m1 = ratio - 1'b1;
        lim      = ratio_m1[DIVW-1:0];
        tick     = (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0) |=> (!tick || lim != $past(lim)))
        else $error("tick too close"); // R2

endmodule

// File: rtl/enc_filter.sv
module enc_filter #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    output logic q
);
    localparam int CNTW = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;

    logic [CNTW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            run <= '0;
        end else if (tick) begin
            if (din != q) begin
                if (run == CNTW'(SAMPLES-1)) begin
                    q   <= din;
                    run <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end else begin
                run <= '0;
            end
        end
    end

    AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(q))
        else $error("filter moved off tick"); // R3

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        tick && (din == q) |=> $stable(q))
        else $error("filter moved to non-sampled level"); // R3

endmodule

// File: rtl/enc_position.sv
module enc_position
    import enc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a,
    input  logic          b,
    input  logic          idx,
    input  cnt_mode_e     mode,
    input  logic [1:0]    pattern,
    input  logic          err_clr,
    output logic [CW-1:0] count,
    output logic          err_flag
);
    logic pa, pb, pi;
    logic da, db, err_evt, step_en, step_up, idx_hit;

    always_comb begin
        da      = a ^ pa;
        db      = b ^ pb;
        err_evt = da & db;
        step_en = (mode == MODE_4X) ? (da ^ db) : (da & ~db);
        step_up = a ^ pb;
        idx_hit = idx & ~pi & index_match(mode, pattern, a, b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pa <= 1'b0;
            pb <= 1'b0;
            pi <= 1'b0;
        end else begin
            pa <= a;
            pb <= b;
            pi <= idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (idx_hit) count <= '0;
        else if (step_en) count <= step_up ? count + 1'b1 : count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          err_flag <= 1'b0;
        else if (err_evt) err_flag <= 1'b1;
        else if (err_clr) err_flag <= 1'b0;
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !idx_hit |=> ((count - $past(count)) == CW'(1) || (count - $past(count)) == '1
                      || count == $past(count)))
        else $error("count jumped"); // R5

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag)
        else $error("error flag dropped"); // R9

    AST_ERR_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (err_evt && !idx_hit) |=> $stable(count))
        else $error("count stepped on illegal transition"); // R9

    AST_2X_B_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_2X && db && !da && !idx_hit) |=> $stable(count))
        else $error("2x counted a B edge"); // R6

endmodule

// File: rtl/enc_front.sv
module enc_front
    import enc_pkg::*;
#(
    parameter int CW      = 16,
    parameter int SAMPLES = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          phase_a_in,
    input  logic          phase_b_in,
    input  logic          index_in,
    input  logic          mode_4x,
    input  logic          ctl_we,
    input  logic [15:0]   ctl_wdata,
    output logic [15:0]   ctl_rdata,
    input  logic          err_clr,
    output logic [CW-1:0] pos_count,
    output logic          err_flag,
    output logic          err_irq
);
    localparam int NLINES = 3;

    ctl_t              ctl_q;
    logic              tick;
    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic [NLINES-1:0] use_lines;
    logic              unused_wbits;

    assign unused_wbits = ^{ctl_wdata[15:11], ctl_wdata[3:0]};

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_we) ctl_q <= word_to_ctl(ctl_wdata[10:4]);
    end

    assign ctl_rdata = ctl_to_word(ctl_q);

    enc_prescaler #(.DIVW(MAX_SHIFT)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .div_code (ctl_q.div_code),
        .tick     (tick)
    );

    assign raw_lines = {index_in, phase_b_in, phase_a_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        enc_filter #(.SAMPLES(SAMPLES)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .din  (raw_lines[g]),
            .q    (filt_lines[g])
        );
    end

    assign use_lines = ctl_q.filt_en ? filt_lines : raw_lines;

    enc_position #(.CW(CW)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .a        (use_lines[0]),
        .b        (use_lines[1]),
        .idx      (use_lines[2]),
        .mode     (cnt_mode_e'(mode_4x)),
        .pattern  (ctl_q.pattern),
        .err_clr  (err_clr),
        .count    (pos_count),
        .err_flag (err_flag)
    );

    assign err_irq = err_flag & ~ctl_q.err_mask;

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_rdata[10:4] == $past(ctl_wdata[10:4])))
        else $error("control write lost"); // R1

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> $stable(ctl_rdata))
        else $error("control changed without write"); // R1

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> (err_flag && !ctl_rdata[8]))
        else $error("interrupt not masked"); // R10

endmodule

// File: tb/sim_enc_front.sv
`timescale 1ns/1ps
module sim_enc_front;
    logic        clk = 0;
    logic        rst = 1;
    logic        pa_i = 0, pb_i = 0, ix_i = 0, m4 = 1;
    logic        we = 0, eclr = 0;
    logic [15:0] wd = 0;
    logic [15:0] rd, pos;
    logic        ef, eirq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model state
    logic        ma = 0, mb = 0, mi = 0, merr = 0;
    logic [15:0] mcnt = 0;
    logic [1:0]  mpat = 0;
    logic        mmask = 0;

    always #5 clk = ~clk;

    enc_front u0 (
        .clk(clk), .rst(rst), .phase_a_in(pa_i), .phase_b_in(pb_i), .index_in(ix_i),
        .mode_4x(m4), .ctl_we(we), .ctl_wdata(wd), .ctl_rdata(rd), .err_clr(eclr),
        .pos_count(pos), .err_flag(ef), .err_irq(eirq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl_word(input logic [1:0] pat, input logic msk,
                                             input logic fen, input logic [2:0] code);
        return {5'b0, pat, msk, fen, code, 4'b0};
    endfunction

    function automatic int ratio_of(input int code);
        int r [8] = '{1, 2, 4, 16, 32, 64, 128, 256};
        return r[code];
    endfunction

    function automatic bit pat_hit(input bit four, input logic [1:0] p, input logic a, input logic b);
        if (four) return (a == p[0]) && (b == p[1]);
        if (p[1]) return b == p[0];
        return a == p[0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; pa_i = 0; pb_i = 0; ix_i = 0; we = 0; eclr = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        ma = 0; mb = 0; mi = 0; merr = 0; mcnt = 0; mpat = 0; mmask = 0;
    endtask

    task automatic wr(input logic [15:0] w);
        @(negedge clk);
        we = 1; wd = w;
        @(negedge clk);
        we = 0;
    endtask

    // drive one raw sample, compare after the next edge
    task automatic step(input logic a, input logic b, input logic i);
        bit da, db, hit;
        string tag;
        @(negedge clk);
        pa_i = a; pb_i = b; ix_i = i;
        da = (a != ma); db = (b != mb);
        hit = i && !mi && pat_hit(m4, mpat, a, b);
        tag = m4 ? "R5" : "R6";
        if (i && !mi) tag = m4 ? "R7" : "R8";
        else if (da && db) tag = "R9";
        if (da && db) merr = 1;
        if (hit) mcnt = 0;
        else if (!(da && db) && (m4 ? (da || db) : da))
            mcnt = (a ^ mb) ? mcnt + 1 : mcnt - 1;
        ma = a; mb = b; mi = i;
        @(negedge clk);
        chk(pos == mcnt, tag, pos, mcnt);
        chk(ef == merr, "R9", ef, merr);
        chk(eirq == (merr & ~mmask), "R10", eirq, merr & ~mmask);
    endtask

    task automatic fwd(); if (ma == mb) step(~ma, mb, 0); else step(ma, ~mb, 0); endtask
    task automatic back(); if (ma == mb) step(ma, ~mb, 0); else step(~ma, mb, 0); endtask

    task automatic rand_walk(input int n);
        for (int k = 0; k < n; k++) begin
            int r = $urandom_range(0, 19);
            if (k % 60 == 0) begin
                mpat = 2'($urandom_range(0, 3));
                mmask = 1'($urandom_range(0, 1));
                wr(ctl_word(mpat, mmask, 0, 0));
            end
            if (r < 7) fwd();
            else if (r < 13) back();
            else if (r < 15) step(ma, ~mb, 0);
            else if (r == 15) step(~ma, ~mb, 0);
            else if (r < 18) begin step(ma, mb, 1); step(ma, mb, 0); end
            else begin
                @(negedge clk); eclr = 1; merr = 0;
                @(negedge clk); eclr = 0;
                chk(ef == 0, "R9", ef, 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        do_reset();
        // R1 reset state and readback
        chk(rd == 16'h0000, "R1", rd, 0);
        chk(pos == 0, "R1", pos, 0);
        chk(ef == 0 && eirq == 0, "R1", {ef, eirq}, 0);
        wr(16'hFFFF);
        chk(rd == 16'h07F0, "R1", rd, 16'h07F0);
        wr(16'h0530);
        chk(rd == 16'h0530, "R1", rd, 16'h0530);

        // R5 / R4 / R11 directed in 4x raw mode
        do_reset(); m4 = 1;
        @(negedge clk); pa_i = 1; ma = 1;
        @(negedge clk);
        chk(pos == 16'd1, "R4", pos, 1);
        mcnt = 1;
        fwd(); fwd(); fwd();
        chk(pos == 16'd4, "R5", pos, 4);
        for (int k = 0; k < 5; k++) back();
        chk(pos == 16'hFFFF, "R11", pos, 16'hFFFF);
        fwd();
        chk(pos == 16'h0000, "R11", pos, 0);

        // R9 / R10 directed
        step(~ma, ~mb, 0);
        chk(ef == 1 && pos == 0, "R9", {ef, pos}, 17'h10000);
        wr(ctl_word(0, 1, 0, 0)); mmask = 1;
        chk(eirq == 0, "R10", eirq, 0);
        @(negedge clk); eclr = 1; @(negedge clk); eclr = 0; merr = 0;
        chk(ef == 0, "R9", ef, 0);

        // R7 directed: pattern B=1 A=0
        do_reset(); m4 = 1; mpat = 2'b10;
        wr(ctl_word(mpat, 0, 0, 0));
        fwd(); fwd(); fwd();              // state A=0 B=1, count 3
        step(ma, mb, 1); step(ma, mb, 0);
        chk(pos == 0, "R7", pos, 0);

        rand_walk(500);

        // R6 / R8 in 2x mode
        do_reset(); m4 = 0; mpat = 2'b11;
        wr(ctl_word(mpat, 0, 0, 0));
        step(1, 0, 0); step(1, 1, 0);
        chk(pos == 1, "R6", pos, 1);
        step(1, 1, 1); step(1, 1, 0);
        chk(pos == 0, "R8", pos, 0);
        rand_walk(500);

        // R2 / R3 filtered latency for every code
        for (int c = 0; c < 8; c++) begin
            int lat, r;
            do_reset(); m4 = 1;
            wr(ctl_word(0, 0, 1, 3'(c)));
            r = ratio_of(c);
            @(negedge clk); pa_i = 1;
            lat = 0;
            while (pos == 0 && lat < 2000) begin @(negedge clk); lat++; end
            chk(lat >= 2*r+2 && lat <= 3*r+1, "R2", lat, 2*r+2);
            chk(pos == 1, "R3", pos, 1);
        end

        // R3 glitch rejection
        for (int c = 0; c < 3; c++) begin
            int r;
            do_reset(); m4 = 1;
            wr(ctl_word(0, 0, 1, 3'(c)));
            r = ratio_of(c);
            @(negedge clk); pa_i = 1;
            repeat (2*r - 1) @(negedge clk);
            pa_i = 0;
            repeat (8*r + 4) @(negedge clk);
            chk(pos == 0, "R3", pos, 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule